// File: doc/BRIEF.md
# Flag Offset Configuration Register with Serial Loader

This block holds the two threshold offsets that a FIFO's programmable flag logic compares against: one offset measured from the empty boundary and one measured from the full boundary. At master reset it samples three select inputs. Together they pick one of eight default offsets, and the same value is written to both registers. One of those three inputs also decides whether the offsets may be rewritten later.

Once master reset has ended, and if serial rewriting was enabled, software or a board controller can rewrite both offsets one bit per write-clock edge. It drives a serial data input while two active-low controls are held low together. The empty offset is loaded first and the full offset second. Each offset goes in least significant bit first. A partial reset of the FIFO leaves this block untouched, so the thresholds survive a mid-operation flush.

Top module: `flag_offset_cfg`

## Requirements
- R1: While `mrs` is high at a rising clock edge, both `empty_ofs` and `full_ofs` take the value 2^(k+3)-1 clamped to AW ones, where k = {`load_n`,`sel_hi`,`sel_lo`} read as a 3-bit number (`load_n` is bit 2). With AW=10 the eight values run from 7 up to 1023.
- R2: At master reset `serial_mode` is set to 1 when `load_n` is low and to 0 when `load_n` is high. It then holds that value until the next master reset.
- R3: When not in master reset, an edge with `serial_mode`=1 and both `load_n` and `ser_en_n` low writes `ser_din` into exactly one offset bit.
- R4: Serial bit positions follow a fixed order. The first AW loaded bits fill `empty_ofs` bits 0 to AW-1, LSB first. The next AW bits fill `full_ofs` in the same way. The 2*AW+1-th bit starts again at `empty_ofs` bit 0.
- R5: An edge where `load_n` or `ser_en_n` is high changes neither offset and does not advance the bit position.
- R6: With `serial_mode`=0, no pattern on `load_n`, `ser_en_n` or `ser_din` changes either offset.
- R7: `prst` has no effect on the offsets, on `serial_mode`, or on the serial bit position.
- R8: A master reset during a partial serial load discards the bit position. The next serial bit after reset goes to `empty_ofs` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrs | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset of the FIFO; ignored here |
| sel_lo | input | 1 | Default select bit 0, sampled at master reset |
| sel_hi | input | 1 | Default select bit 1, sampled at master reset |
| load_n | input | 1 | Default select bit 2 at master reset; active-low serial load strobe afterwards |
| ser_en_n | input | 1 | Active-low serial enable |
| ser_din | input | 1 | Serial data bit |
| empty_ofs | output | AW | Offset from the empty boundary |
| full_ofs | output | AW | Offset from the full boundary |
| serial_mode | output | 1 | 1 when serial rewriting is enabled |

## Verification
The assertions take for granted the following about the inputs:
- `ser_en_n` stays high and `ser_din` stays low during master reset.
- Outside reset, select inputs other than `load_n` play no part.

The stimulus keeps within these assumptions. It raises `ser_en_n` before every master reset and drives the shift pair low only in deliberate load windows. It also pulses `prst` both inside and outside such windows. This lets the one-bit-per-edge and retention properties be observed against defaults as well as serially written values.

// File: rtl/flag_cfg_pkg.sv
package flag_cfg_pkg;

    localparam int SEL_W      = 3;
    localparam int BASE_ONES  = 3;

    typedef enum logic {
        PROG_LOCKED = 1'b0,
        PROG_SERIAL = 1'b1
    } prog_mode_e;

    typedef struct packed {
        logic load_n;
        logic sel_hi;
        logic sel_lo;
    } reset_sel_t;

    // Number of low-order ones in the default offset for a select code.
    function automatic int unsigned default_ones(input reset_sel_t s);
        return int'(s) + BASE_ONES;
    endfunction

    function automatic prog_mode_e mode_from_sel(input reset_sel_t s);
        return s.load_n ? PROG_LOCKED : PROG_SERIAL;
    endfunction

endpackage

// File: rtl/flag_cfg_defaults.sv
module flag_cfg_defaults
    import flag_cfg_pkg::*;
#(
    parameter int AW = 10
) (
    input  reset_sel_t      sel,
    output logic [AW-1:0]   dflt,
    output prog_mode_e      mode
);
    int unsigned ones;

    always_comb ones = default_ones(sel);

    for (genvar b = 0; b < AW; b++) begin : g_bit
        assign dflt[b] = (b < ones);
    end

    assign mode = mode_from_sel(sel);
endmodule

// File: rtl/flag_cfg_shifter.sv
module flag_cfg_shifter
    import flag_cfg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   dflt,
    input  prog_mode_e      mode_in,
    input  logic            load_n,
    input  logic            ser_en_n,
    input  logic            ser_din,
    output logic [AW-1:0]   empty_q,
    output logic [AW-1:0]   full_q,
    output prog_mode_e      mode_q
);
    localparam int TOTAL = 2 * AW;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int IDX_W = (AW > 1) ? $clog2(AW) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] SPLIT = CNT_W'(AW);

    logic [CNT_W-1:0] pos;
    logic             in_full;
    logic [IDX_W-1:0] slot;
    logic             shift_en;

    always_comb begin
        in_full  = (pos >= SPLIT);
        slot     = in_full ? IDX_W'(pos - SPLIT) : IDX_W'(pos);
        shift_en = (mode_q == PROG_SERIAL) && !load_n && !ser_en_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= dflt;
            full_q  <= dflt;
            mode_q  <= mode_in;
            pos     <= '0;
        end else if (shift_en) begin
            if (in_full) full_q[slot]  <= ser_din;
            else         empty_q[slot] <= ser_din;
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/flag_offset_cfg.sv
module flag_offset_cfg
    import flag_cfg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic            clk,
    input  logic            mrs,
    input  logic            prst,
    input  logic            sel_lo,
    input  logic            sel_hi,
    input  logic            load_n,
    input  logic            ser_en_n,
    input  logic            ser_din,
    output logic [AW-1:0]   empty_ofs,
    output logic [AW-1:0]   full_ofs,
    output logic            serial_mode
);
    reset_sel_t      sel;
    logic [AW-1:0]   dflt;
    prog_mode_e      mode_d, mode_q;

    assign sel = '{load_n: load_n, sel_hi: sel_hi, sel_lo: sel_lo};

    flag_cfg_defaults #(.AW(AW)) u_dflt (
        .sel  (sel),
        .dflt (dflt),
        .mode (mode_d)
    );

    flag_cfg_shifter #(.AW(AW)) u_shift (
        .clk      (clk),
        .rst      (mrs),
        .dflt     (dflt),
        .mode_in  (mode_d),
        .load_n   (load_n),
        .ser_en_n (ser_en_n),
        .ser_din  (ser_din),
        .empty_q  (empty_ofs),
        .full_q   (full_ofs),
        .mode_q   (mode_q)
    );

    assign serial_mode = (mode_q == PROG_SERIAL);
endmodule

// File: rtl/flag_offset_cfg_chk.sv
module flag_offset_cfg_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          mrs,
    input logic          prst,
    input logic          load_n,
    input logic          ser_en_n,
    input logic [AW-1:0] empty_ofs,
    input logic [AW-1:0] full_ofs,
    input logic          serial_mode
);
    // R1
    dflt_equal_chk: assert property (@(posedge clk)
        mrs |=> (empty_ofs == full_ofs) && ((empty_ofs & (empty_ofs + 1'b1)) == '0));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (mrs)
        1'b1 |=> $stable(serial_mode));

    // R3
    one_bit_chk: assert property (@(posedge clk) disable iff (mrs)
        1'b1 |=> $countones({empty_ofs, full_ofs} ^ $past({empty_ofs, full_ofs})) <= 1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (mrs)
        (load_n || ser_en_n) |=> $stable(empty_ofs) && $stable(full_ofs));

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (mrs)
        !serial_mode |=> $stable(empty_ofs) && $stable(full_ofs));

    // R7
    prst_keep_chk: assert property (@(posedge clk) disable iff (mrs)
        (prst && (load_n || ser_en_n)) |=> $stable(empty_ofs) && $stable(full_ofs)
                                           && $stable(serial_mode));
endmodule

bind flag_offset_cfg flag_offset_cfg_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_flag_offset_cfg.sv
`timescale 1ns/1ps
module sim_flag_offset_cfg;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic mrs = 1'b1, prst = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0;
    logic load_n = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
    logic [AW-1:0] empty_ofs, full_ofs;
    logic serial_mode;

    always #4 clk = ~clk;

    flag_offset_cfg #(.AW(AW)) u0 (.*);

    // behavioural reference
    logic [AW-1:0] m_e, m_f;
    logic          m_mode;
    int            m_pos;
    int            n_chk = 0, n_fail = 0;
    string         tag = "R1";
    bit            done = 0;

    function automatic logic [AW-1:0] dval(int k);
        longint v = (64'd1 << (k + 3)) - 1;
        if (k + 3 >= AW) v = (64'd1 << AW) - 1;
        return v[AW-1:0];
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (mrs) begin
            m_e = dval({load_n, sel_hi, sel_lo});
            m_f = m_e; m_mode = !load_n; m_pos = 0;
        end else if (m_mode && !load_n && !ser_en_n) begin
            if (m_pos < AW) m_e[m_pos] = ser_din;
            else            m_f[m_pos - AW] = ser_din;
            m_pos = (m_pos + 1) % (2 * AW);
        end
        @(negedge clk);
        check({tag, " empty"}, 32'(empty_ofs), 32'(m_e));
        check({tag, " full"},  32'(full_ofs),  32'(m_f));
        check({tag, " mode"},  32'(serial_mode), 32'(m_mode));
    endtask

    task automatic do_reset(int k);
        ser_en_n = 1'b1; ser_din = 1'b0; mrs = 1'b1;
        {load_n, sel_hi, sel_lo} = 3'(k);
        tick(); tick();
        mrs = 1'b0; load_n = 1'b1; sel_lo = 1'b0; sel_hi = 1'b0;
        tick();
    endtask

    task automatic shift_bits(logic [63:0] bits, int n);
        for (int i = 0; i < n; i++) begin
            load_n = 1'b0; ser_en_n = 1'b0; ser_din = bits[i];
            tick();
        end
        load_n = 1'b1; ser_en_n = 1'b1; ser_din = 1'b0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        // R1 / R2: every reset-time selection
        for (int k = 0; k < 8; k++) begin
            tag = "R1";
            do_reset(k);
            check("R1 default", 32'(empty_ofs), 32'(dval(k)));
            check("R2 mode", 32'(serial_mode), 32'(k < 4));
        end

        // R3 / R4: full serial load, empty 2A5 then full 15A
        tag = "R3";
        do_reset(2);
        shift_bits({44'd0, 10'h15A, 10'h2A5}, 2 * AW);
        check("R4 empty order", 32'(empty_ofs), 32'h2A5);
        check("R4 full order",  32'(full_ofs),  32'h15A);
        // R4 wrap: next bits land in empty again
        tag = "R4";
        shift_bits(64'h3, 2);
        check("R4 wrap", 32'(empty_ofs), 32'h2A7);

        // R5: only one control low
        tag = "R5";
        load_n = 1'b0; ser_en_n = 1'b1; ser_din = 1'b1; tick(); tick();
        load_n = 1'b1; ser_en_n = 1'b0; tick(); tick();
        ser_en_n = 1'b1; ser_din = 1'b0; tick();
        check("R5 hold", 32'(empty_ofs), 32'h2A7);

        // R7: partial reset mid-stream and idle
        tag = "R7";
        prst = 1'b1; tick(); tick(); prst = 1'b0; tick();
        shift_bits(64'h0, 1);
        check("R7 position kept", 32'(empty_ofs), 32'h2A3);
        prst = 1'b1; load_n = 1'b0; ser_en_n = 1'b0; ser_din = 1'b1; tick();
        prst = 1'b0; load_n = 1'b1; ser_en_n = 1'b1; ser_din = 1'b0; tick();
        check("R7 shift during prst", 32'(empty_ofs), 32'h2AB);

        // R8: master reset mid-load restarts at empty bit 0
        tag = "R8";
        do_reset(0);
        shift_bits(64'h0, 1);
        check("R8 restart", 32'(empty_ofs), 32'h006);

        // R6: locked mode ignores serial pins
        tag = "R6";
        do_reset(6);
        shift_bits(64'h0, 2 * AW);
        check("R6 locked", 32'(empty_ofs), 32'h1FF);
        check("R6 locked full", 32'(full_ofs), 32'h1FF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule